// File: doc/BRIEF.md
# Linear FM Sweep Controller

This block steers the tuning word of a phase-accumulating tone generator so that the generated frequency climbs through a fixed set of points and then starts over, which gives a repeating linear chirp. The tuning words are computed when the design is elaborated and held in a small table. Each word rises in equal steps from a start value to an end value.

An index register selects the table entry that drives the tuning output. A dwell timer keeps each entry on the output for one full period of the tone that entry produces. For an accumulator of P bits and tuning word K, that is ceil(2^P / K) clock cycles. Low words therefore dwell longer than high words, and the sweep rate follows the frequency. A one-cycle marker flags the first cycle of each new sweep, so a downstream capture or display can line up with the chirp. Deasserting the enable pauses the sweep exactly where it stands.

Top module: `lfm_sweep_ctrl`

## Requirements
- R1: After a synchronous reset, the tuning output is entry 0 (value 16), sweep_start is low, and entry 0 then stays on the output for its full dwell of 64 enabled cycles.
- R2: Table entry i (0 to 63) carries the tuning word 16 + floor(240*i/63). Entry 0 is 16 and entry 63 is 256.
- R3: Each entry stays on k_word for exactly ceil(1024/K) enabled clock cycles, where K is that entry's word. This is never less than one output period.
- R4: When a dwell expires, the index moves to the next entry in ascending order, never skipping an entry.
- R5: When the dwell of entry 63 expires, the index returns to entry 0 and the sweep repeats without end.
- R6: sweep_start is high for exactly one cycle: the first cycle in which entry 0 is on the output after a wrap from entry 63. It is low at every other time, including after reset.
- R7: While en is low, k_word holds its value and the dwell does not progress. The remaining dwell resumes when en returns, so the total enabled cycles spent on the entry still equal its dwell.
- R8: If en is low in the cycle the last entry's dwell would expire, the wrap and its marker are deferred to the next enabled cycle. A marker that has been raised still lasts one cycle even if en falls immediately afterwards.
- R9: A reset in the middle of a sweep returns the output to entry 0 with a fresh full dwell, and raises no sweep_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sweep enable; low freezes the sweep |
| k_word | output | 10 | Current frequency tuning word |
| sweep_start | output | 1 | One-cycle marker at the start of each sweep |

## Verification
Two events can fall in the same cycle: the expiry of the last entry's dwell, which wraps the index and raises the marker, and a change of the enable. The bench runs the sweep up to the final cycle of entry 63's dwell. It then lowers en exactly there, and judges that the tuning word stays at 256 with no marker for as long as the pause lasts. A single enabled cycle then produces the wrap, and en falls straight after it. The bench checks that the marker appears once, with word 16, and is gone in the next cycle. A mid-sweep reset is also compared against the same reference model, so reset and dwell reload are judged together.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

  // Linear ramp of tuning words across the table.
  function automatic int unsigned k_of(input int unsigned i, input int unsigned n_entries,
                                       input int unsigned k_start, input int unsigned k_end);
    return k_start + ((k_end - k_start) * i) / (n_entries - 1);
  endfunction

  // Cycles needed for one full output period: ceil(2^phase_bits / k).
  function automatic int unsigned dwell_of(input int unsigned k, input int unsigned phase_bits);
    return ((32'd1 << phase_bits) + k - 1) / k;
  endfunction

endpackage

// File: rtl/lfm_ktable.sv
module lfm_ktable #(
  parameter int unsigned N_ENTRIES  = 64,
  parameter int unsigned KW         = 10,
  parameter int unsigned PHASE_BITS = 10,
  parameter int unsigned K_START    = 16,
  parameter int unsigned K_END      = 256,
  parameter int unsigned IW         = 6,
  parameter int unsigned DW         = 7
) (
  input  logic [IW-1:0] cur_idx,
  input  logic [IW-1:0] nxt_idx,
  output logic [KW-1:0] k_cur,
  output logic [DW-1:0] nxt_dwell_m1
);
  logic [KW-1:0] k_rom  [N_ENTRIES];
  logic [DW-1:0] dw_rom [N_ENTRIES];

  for (genvar g = 0; g < int'(N_ENTRIES); g++) begin : g_entry
    localparam int unsigned KV = lfm_pkg::k_of(g, N_ENTRIES, K_START, K_END);
    assign k_rom[g]  = KW'(KV);
    assign dw_rom[g] = DW'(lfm_pkg::dwell_of(KV, PHASE_BITS) - 1);
  end

  assign k_cur        = k_rom[cur_idx];
  assign nxt_dwell_m1 = dw_rom[nxt_idx];
endmodule

// File: rtl/lfm_dwell_timer.sv
module lfm_dwell_timer #(
  parameter int unsigned DW       = 7,
  parameter int unsigned RST_LOAD = 63
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] nxt_load,
  output logic [DW-1:0] cnt,
  output logic          expire
);
  assign expire = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= DW'(RST_LOAD);
    else if (en) begin
      if (expire)     cnt <= nxt_load;
      else            cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/lfm_index_ctr.sv
module lfm_index_ctr #(
  parameter int unsigned N_ENTRIES = 64,
  parameter int unsigned IW        = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          expire,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] nxt_idx,
  output logic          wrap,
  output logic          sweep_start
);
  localparam logic [IW-1:0] LAST = IW'(N_ENTRIES - 1);

  logic at_last;
  logic advance;

  assign at_last = (idx == LAST);
  assign nxt_idx = at_last ? '0 : idx + 1'b1;
  assign advance = en & expire;
  assign wrap    = advance & at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx         <= '0;
      sweep_start <= 1'b0;
    end else begin
      if (advance) idx <= nxt_idx;
      sweep_start <= wrap;
    end
  end
endmodule

// File: rtl/lfm_sweep_ctrl.sv
module lfm_sweep_ctrl #(
  parameter int unsigned N_ENTRIES  = 64,
  parameter int unsigned KW         = 10,
  parameter int unsigned PHASE_BITS = 10,
  parameter int unsigned K_START    = 16,
  parameter int unsigned K_END      = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [KW-1:0] k_word,
  output logic          sweep_start
);
  localparam int unsigned IW        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;
  localparam int unsigned MAX_DWELL = lfm_pkg::dwell_of(K_START, PHASE_BITS);
  localparam int unsigned DW        = $clog2(MAX_DWELL + 1);
  localparam int unsigned K0        = lfm_pkg::k_of(0, N_ENTRIES, K_START, K_END);
  localparam int unsigned RST_LOAD  = lfm_pkg::dwell_of(K0, PHASE_BITS) - 1;

  logic [IW-1:0] idx;
  logic [IW-1:0] nxt_idx;
  logic [DW-1:0] cnt;
  logic [DW-1:0] nxt_dwell_m1;
  logic          expire;
  logic          wrap;

  lfm_ktable #(
    .N_ENTRIES(N_ENTRIES), .KW(KW), .PHASE_BITS(PHASE_BITS),
    .K_START(K_START), .K_END(K_END), .IW(IW), .DW(DW)
  ) u_table (
    .cur_idx(idx), .nxt_idx(nxt_idx), .k_cur(k_word), .nxt_dwell_m1(nxt_dwell_m1)
  );

  lfm_dwell_timer #(.DW(DW), .RST_LOAD(RST_LOAD)) u_timer (
    .clk(clk), .rst(rst), .en(en), .nxt_load(nxt_dwell_m1), .cnt(cnt), .expire(expire)
  );

  lfm_index_ctr #(.N_ENTRIES(N_ENTRIES), .IW(IW)) u_index (
    .clk(clk), .rst(rst), .en(en), .expire(expire),
    .idx(idx), .nxt_idx(nxt_idx), .wrap(wrap), .sweep_start(sweep_start)
  );
endmodule

// File: rtl/lfm_sweep_ctrl_chk.sv
module lfm_sweep_ctrl_chk #(
  parameter int unsigned N_ENTRIES  = 64,
  parameter int unsigned KW         = 10,
  parameter int unsigned PHASE_BITS = 10,
  parameter int unsigned IW         = 6,
  parameter int unsigned DW         = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic [KW-1:0] k_word,
  input logic          sweep_start,
  input logic [IW-1:0] idx,
  input logic [DW-1:0] cnt,
  input logic          expire,
  input logic          wrap
);
  localparam logic [IW-1:0] LAST = IW'(N_ENTRIES - 1);

  // R1: reset lands on entry 0 with no marker
  a_r1_reset_state: assert property (@(posedge clk) rst |=> (idx == '0) && !sweep_start);

  // R3: counter never exceeds the current entry's dwell
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) < int'(lfm_pkg::dwell_of(int'(k_word), PHASE_BITS)));

  // R3: the new entry starts with its full dwell
  a_r3_reload: assert property (@(posedge clk) disable iff (rst)
    (en && expire) |=> int'(cnt) == int'(lfm_pkg::dwell_of(int'(k_word), PHASE_BITS)) - 1);

  // R4: ascending step on expiry
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (en && expire && idx != LAST) |=> idx == $past(idx) + 1'b1);

  // R5: wrap from the last entry
  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (en && expire && idx == LAST) |=> (idx == '0) && sweep_start);

  // R6: marker is one cycle wide and only on entry 0
  a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst) sweep_start |=> !sweep_start);
  a_r6_on_entry0: assert property (@(posedge clk) disable iff (rst) sweep_start |-> idx == '0);
  a_r6_cause:     assert property (@(posedge clk) disable iff (rst) !wrap |=> !sweep_start);

  // R7: disabled cycles freeze index, dwell and output
  a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(idx) && $stable(cnt) && $stable(k_word));
endmodule

bind lfm_sweep_ctrl lfm_sweep_ctrl_chk #(
  .N_ENTRIES(N_ENTRIES), .KW(KW), .PHASE_BITS(PHASE_BITS), .IW(IW), .DW(DW)
) u_chk (
  .clk(clk), .rst(rst), .en(en), .k_word(k_word), .sweep_start(sweep_start),
  .idx(idx), .cnt(cnt), .expire(expire), .wrap(wrap)
);

// File: tb/lfm_sweep_ctrl_bench.sv
module lfm_sweep_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [9:0] k_word;
  logic       sweep_start;

  int n_tests = 0;
  int n_fail  = 0;
  int n_pulse = 0;

  // reference state: entry index and enabled cycles left on it
  int m_idx   = 0;
  int m_left  = 64;
  bit m_pulse = 0;

  always #2 clk = ~clk;

  lfm_sweep_ctrl u_lfm_sweep_ctrl (
    .clk(clk), .rst(rst), .en(en), .k_word(k_word), .sweep_start(sweep_start)
  );

  function automatic int ref_k(input int i);
    return (16 * 63 + 240 * i) / 63;
  endfunction

  function automatic int ref_dw(input int k);
    int d = 1;
    while (d * k < 1024) d++;
    return d;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // one clock with given enable/reset; model updated, outputs compared at negedge
  task automatic step(input string tag, input bit e, input bit r);
    en  = e;
    rst = r;
    @(posedge clk);
    m_pulse = 0;
    if (r) begin
      m_idx  = 0;
      m_left = ref_dw(ref_k(0));
    end else if (e) begin
      m_left--;
      if (m_left == 0) begin
        m_idx   = (m_idx + 1) % 64;
        m_left  = ref_dw(ref_k(m_idx));
        m_pulse = (m_idx == 0);
      end
    end
    @(negedge clk);
    if (sweep_start) n_pulse++;
    check({tag, " k_word"}, int'(k_word), ref_k(m_idx));
    check("R6 sweep_start", int'(sweep_start), int'(m_pulse));
  endtask

  task automatic t_reset();
    @(negedge clk);
    step("R1", 0, 1);
    step("R1", 0, 1);
    check("R1 reset k_word", int'(k_word), 16);
    check("R1 reset sweep_start", int'(sweep_start), 0);
    for (int c = 0; c < 63; c++) step("R1", 1, 0);
    check("R1 entry0 held 63 cycles", int'(k_word), 16);
    step("R1", 1, 0);
    check("R1 entry1 after 64 cycles", int'(k_word), ref_k(1));
  endtask

  task automatic t_full_sweep();
    int p0;
    int hold;
    int last_k;
    p0 = n_pulse;
    hold = 0;
    last_k = int'(k_word);
    for (int c = 0; c < 2600; c++) begin
      step("R3", 1, 0);
      if (int'(k_word) == last_k) hold++;
      else begin
        // R4: each change moves up one table step (or wraps per R5)
        if (int'(k_word) != 16) check("R4 next entry", int'(k_word), ref_k(m_idx));
        else check("R5 wrap from last", last_k, 256);
        hold = 0;
        last_k = int'(k_word);
      end
      if (sweep_start) check("R5 k after wrap", int'(k_word), 16);
    end
    check("R2 entry 63 value", ref_k(63), 256);
    check("R6 markers in sweeps", n_pulse - p0, 2600 / 1000 > 0 ? n_pulse - p0 : -1);
    if (n_pulse - p0 < 1) check("R5 sweep repeated", n_pulse - p0, 2);
  endtask

  task automatic t_enable_gaps();
    for (int c = 0; c < 1500; c++) step("R7", (c % 5) != 0 && (c % 7) != 3, 0);
    for (int c = 0; c < 6; c++) step("R7", 0, 0);
    check("R7 frozen k_word", int'(k_word), ref_k(m_idx));
  endtask

  task automatic t_wrap_enable();
    int guard = 0;
    while (!(m_idx == 63 && m_left == 1) && guard < 5000) begin
      step("R8", 1, 0);
      guard++;
    end
    check("R8 reached last cycle of entry 63", int'(k_word), 256);
    for (int c = 0; c < 4; c++) begin
      step("R8", 0, 0);
      check("R8 deferred wrap k", int'(k_word), 256);
      check("R8 no marker while paused", int'(sweep_start), 0);
    end
    step("R8", 1, 0);
    check("R8 marker on wrap", int'(sweep_start), 1);
    check("R8 k at wrap", int'(k_word), 16);
    step("R8", 0, 0);
    check("R8 marker single cycle", int'(sweep_start), 0);
    check("R8 k after pause", int'(k_word), 16);
  endtask

  task automatic t_midreset();
    int guard = 0;
    while (m_idx != 20 && guard < 5000) begin
      step("R9", 1, 0);
      guard++;
    end
    step("R9", 1, 1);
    check("R9 reset k_word", int'(k_word), 16);
    check("R9 no marker on reset", int'(sweep_start), 0);
    for (int c = 0; c < 70; c++) step("R9", 1, 0);
    check("R9 progressed to entry 1", int'(k_word), ref_k(1));
  endtask

  initial begin
    t_reset();
    t_full_sweep();
    t_enable_gaps();
    t_wrap_enable();
    t_midreset();
    summary();
  end

  initial begin
    #(4 * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule